// File: doc/BRIEF.md
# Card Reader Command Packet Serial Link

This block sits on the reader side of an asynchronous serial line to a card reader controller. The host hands it a command packet one byte at a time. The packet is made of a node address byte, a protocol control byte, a length byte and the data bytes. The block sends each byte as a character on `txd` and then appends the block check byte, which is the XOR of all bytes of the packet.

Response characters arrive on `rxd`. The block holds a response until its check byte has been seen. It then verifies four things: the XOR check, the parity and stop bits of every character, the length, and the node address. The expected node address is the most recent command address with its two nibbles swapped. A response that passes is released to the host in one burst of consecutive cycles, without the check byte. A response that fails is discarded and `rsp_err` is pulsed. A silence in the middle of a response that lasts longer than a set number of character times also discards the partial packet.

The line rate comes from `CLKS_PER_BIT`. For 9600 baud this is the clock frequency divided by 9600. A character has one start bit, eight data bits sent LSB first, one even parity bit and two stop bits.

Top module: `cardlink_uart`

## Requirements
- R1: Each transmitted character is a low start bit, then 8 data bits LSB first, then an even parity bit (the XOR of the data bits), then two high stop bits. Each bit lasts CLKS_PER_BIT clocks, and `txd` is high whenever no character is being sent.
- R2: Host bytes are sent in the order they are accepted. A byte is accepted in a cycle where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is low while a character is on the line. After the byte marked `cmd_eop`, one extra byte is sent before the next host byte is taken: the XOR of all bytes from the one marked `cmd_sop` onward.
- R3: The expected response address is the address of the latest command (the `cmd_sop` byte) with its high and low nibbles swapped. After reset, it is the nibble swap of DEF_NAD (0x12 gives 0x21).
- R4: A valid response is delivered as address, control, length and data bytes, in order, with no check byte. The bytes come on consecutive cycles with `rsp_valid` high, `rsp_sop` on the first byte and `rsp_eop` on the last.
- R5: A response whose check byte differs from the XOR of the bytes before it is not delivered, and `rsp_err` is high for exactly one cycle.
- R6: A response with a parity error or a low stop bit in any character is not delivered, and `rsp_err` pulses.
- R7: A response whose first byte differs from the expected address of R3 is not delivered, and `rsp_err` pulses.
- R8: A response whose length byte exceeds MAX_LEN is not delivered, and `rsp_err` pulses. The number of characters given by the length byte is still consumed before the check byte is expected.
- R9: A valid response with a length of zero is delivered as exactly three bytes.
- R10: A response is abandoned, with an `rsp_err` pulse, when no character completes within (GAP_CHARS+1)*12*CLKS_PER_BIT clocks of the previous one. The next character then starts a new packet. Shorter gaps do not disturb reception.
- R11: After reset, `txd` is high, `cmd_ready` is high, and `rsp_valid` and `rsp_err` are low.
- R12: Transmission and reception run independently. A command sent while a response is arriving changes neither.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Host offers a command byte |
| cmd_data | input | 8 | Command byte |
| cmd_sop | input | 1 | Byte is the command address (first byte) |
| cmd_eop | input | 1 | Byte is the last data byte of the command |
| cmd_ready | output | 1 | Block takes the offered byte this cycle |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |
| rsp_sop | output | 1 | First byte of a response |
| rsp_eop | output | 1 | Last byte of a response |
| rsp_err | output | 1 | One-cycle pulse: a response was dropped |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |

## Verification
Two functions can be active in the same cycle. One is accepting a command byte and shifting it out. The other is releasing a checked response burst to the host. The bench starts a command and a response in parallel so that their timing overlaps. It judges the result with two separate scoreboards, one for the bytes seen on `txd` and one for the delivered response bytes, and neither may show a missing, extra or changed byte. A second overlap is the gap timer expiring while characters are still arriving. The bench places one gap just below the limit and one well above it, then checks whether the packet is delivered or discarded.

// File: rtl/cl_pkg.sv
package cl_pkg;
   localparam int unsigned CHAR_BITS = 12;

   typedef enum logic [2:0] {
      POS_NAD, POS_PCB, POS_LEN, POS_DATA, POS_BCC
   } rsp_pos_e;

   typedef enum logic [2:0] {
      RX_IDLE, RX_START, RX_BITS, RX_PAR, RX_STOP1, RX_STOP2
   } rx_st_e;

   function automatic logic [7:0] nib_swap(input logic [7:0] b);
      return {b[3:0], b[7:4]};
   endfunction

   function automatic logic even_par(input logic [7:0] b);
      return ^b;
   endfunction
endpackage

// File: rtl/cl_char_tx.sv
module cl_char_tx
   import cl_pkg::*;
#(
   parameter int unsigned CLKS_PER_BIT = 1042
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] data,
   output logic       busy,
   output logic       txd
);
   localparam int unsigned CW = $clog2(CLKS_PER_BIT + 1);
   localparam int unsigned BW = $clog2(CHAR_BITS);
   localparam logic [CW-1:0] RELOAD = CW'(CLKS_PER_BIT - 1);

   logic [CHAR_BITS-1:0] frame;
   logic [CW-1:0]        cnt;
   logic [BW-1:0]        bitn;
   logic                 busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame  <= '1;
         cnt    <= '0;
         bitn   <= '0;
         busy_q <= 1'b0;
      end else if (start && !busy_q) begin
         frame  <= {2'b11, even_par(data), data, 1'b0};
         cnt    <= RELOAD;
         bitn   <= '0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end else begin
            cnt <= RELOAD;
            if (bitn == BW'(CHAR_BITS - 1)) begin
               busy_q <= 1'b0;
            end else begin
               bitn  <= bitn + 1'b1;
               frame <= {1'b1, frame[CHAR_BITS-1:1]};
            end
         end
      end
   end

   assign busy = busy_q;
   assign txd  = busy_q ? frame[0] : 1'b1;
endmodule

// File: rtl/cl_char_rx.sv
module cl_char_rx
   import cl_pkg::*;
#(
   parameter int unsigned CLKS_PER_BIT = 1042
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rxd,
   output logic [7:0] rx_byte,
   output logic       rx_bvalid,
   output logic       rx_berr
);
   localparam int unsigned CW = $clog2(CLKS_PER_BIT + 1);
   localparam logic [CW-1:0] FULL = CW'(CLKS_PER_BIT - 1);
   localparam logic [CW-1:0] HALF = CW'(CLKS_PER_BIT / 2 - 1);

   logic          s1, s2;
   rx_st_e        st;
   logic [CW-1:0] cnt;
   logic [2:0]    bitn;
   logic [7:0]    sh;
   logic          perr, ferr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b1;
         s2 <= 1'b1;
      end else begin
         s1 <= rxd;
         s2 <= s1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= RX_IDLE;
         cnt       <= '0;
         bitn      <= '0;
         sh        <= '0;
         perr      <= 1'b0;
         ferr      <= 1'b0;
         rx_bvalid <= 1'b0;
         rx_berr   <= 1'b0;
      end else begin
         rx_bvalid <= 1'b0;
         if (st == RX_IDLE) begin
            if (!s2) begin
               st  <= RX_START;
               cnt <= HALF;
            end
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end else begin
            cnt <= FULL;
            case (st)
               RX_START: begin
                  if (!s2) begin
                     st   <= RX_BITS;
                     bitn <= '0;
                  end else begin
                     st <= RX_IDLE;
                  end
               end
               RX_BITS: begin
                  sh <= {s2, sh[7:1]};
                  if (bitn == 3'd7) st <= RX_PAR;
                  else bitn <= bitn + 1'b1;
               end
               RX_PAR: begin
                  perr <= (s2 != even_par(sh));
                  st   <= RX_STOP1;
               end
               RX_STOP1: begin
                  ferr <= !s2;
                  st   <= RX_STOP2;
               end
               default: begin
                  rx_bvalid <= 1'b1;
                  rx_berr   <= perr | ferr | !s2;
                  st        <= RX_IDLE;
               end
            endcase
         end
      end
   end

   assign rx_byte = sh;
endmodule

// File: rtl/cl_cmd_framer.sv
module cl_cmd_framer
   import cl_pkg::*;
#(
   parameter logic [7:0] DEF_NAD = 8'h12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_data,
   input  logic       cmd_sop,
   input  logic       cmd_eop,
   output logic       cmd_ready,
   input  logic       chr_busy,
   output logic       chr_start,
   output logic [7:0] chr_data,
   output logic [7:0] exp_nad
);
   logic [7:0] bcc;
   logic       pend;
   logic       take;
   logic [7:0] bcc_next;

   assign cmd_ready = !chr_busy && !pend;
   assign take      = cmd_valid && cmd_ready;
   assign bcc_next  = cmd_sop ? cmd_data : (bcc ^ cmd_data);
   assign chr_start = take || (pend && !chr_busy);
   assign chr_data  = pend ? bcc : cmd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcc     <= '0;
         pend    <= 1'b0;
         exp_nad <= nib_swap(DEF_NAD);
      end else if (take) begin
         bcc <= bcc_next;
         if (cmd_sop) exp_nad <= nib_swap(cmd_data);
         if (cmd_eop) pend <= 1'b1;
      end else if (pend && !chr_busy) begin
         pend <= 1'b0;
      end
   end
endmodule

// File: rtl/cl_rsp_checker.sv
module cl_rsp_checker
   import cl_pkg::*;
#(
   parameter int unsigned CLKS_PER_BIT = 1042,
   parameter int unsigned MAX_LEN      = 32,
   parameter int unsigned GAP_CHARS    = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] rx_byte,
   input  logic       rx_bvalid,
   input  logic       rx_berr,
   input  logic [7:0] exp_nad,
   output logic       rsp_valid,
   output logic [7:0] rsp_data,
   output logic       rsp_sop,
   output logic       rsp_eop,
   output logic       rsp_err
);
   localparam int unsigned DEPTH = MAX_LEN + 3;
   localparam int unsigned AW    = $clog2(DEPTH);

   rsp_pos_e      pos;
   logic [7:0]    cnt;
   logic [7:0]    len;
   logic [7:0]    bcc;
   logic          bad;
   logic          err_q;
   logic          unl;
   logic [AW-1:0] optr;
   logic [AW-1:0] total;
   logic [7:0]    mem [DEPTH];
   logic          abort;
   logic          bad_n;

   generate
      if (GAP_CHARS == 0) begin : g_nogap
         assign abort = 1'b0;
      end else begin : g_gap
         localparam int unsigned GAP_CLKS = (GAP_CHARS + 1) * CHAR_BITS * CLKS_PER_BIT;
         localparam int unsigned GW = $clog2(GAP_CLKS + 1);
         logic [GW-1:0] gap;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) gap <= '0;
            else if (rx_bvalid || pos == POS_NAD) gap <= '0;
            else gap <= gap + 1'b1;
         end
         assign abort = (pos != POS_NAD) && !rx_bvalid && (gap == GW'(GAP_CLKS - 1));
      end
   endgenerate

   assign bad_n = bad | rx_berr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos   <= POS_NAD;
         cnt   <= '0;
         len   <= '0;
         bcc   <= '0;
         bad   <= 1'b0;
         err_q <= 1'b0;
         unl   <= 1'b0;
         optr  <= '0;
         total <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         err_q <= 1'b0;
         if (unl) begin
            if (optr == total - 1'b1) unl <= 1'b0;
            optr <= optr + 1'b1;
         end
         if (abort) begin
            pos   <= POS_NAD;
            err_q <= 1'b1;
         end else if (rx_bvalid) begin
            case (pos)
               POS_NAD: begin
                  mem[0] <= rx_byte;
                  bcc    <= rx_byte;
                  bad    <= rx_berr | (rx_byte != exp_nad);
                  pos    <= POS_PCB;
               end
               POS_PCB: begin
                  mem[1] <= rx_byte;
                  bcc    <= bcc ^ rx_byte;
                  bad    <= bad_n;
                  pos    <= POS_LEN;
               end
               POS_LEN: begin
                  mem[2] <= rx_byte;
                  bcc    <= bcc ^ rx_byte;
                  len    <= rx_byte;
                  cnt    <= '0;
                  bad    <= bad_n | (32'(rx_byte) > MAX_LEN);
                  pos    <= (rx_byte == 8'd0) ? POS_BCC : POS_DATA;
               end
               POS_DATA: begin
                  if (32'(cnt) < MAX_LEN) mem[AW'({1'b0, cnt} + 9'd3)] <= rx_byte;
                  bcc <= bcc ^ rx_byte;
                  bad <= bad_n;
                  cnt <= cnt + 1'b1;
                  if (cnt + 8'd1 == len) pos <= POS_BCC;
               end
               default: begin
                  if (!bad_n && bcc == rx_byte) begin
                     unl   <= 1'b1;
                     optr  <= '0;
                     total <= AW'({1'b0, len} + 9'd3);
                  end else begin
                     err_q <= 1'b1;
                  end
                  pos <= POS_NAD;
               end
            endcase
         end
      end
   end

   assign rsp_valid = unl;
   assign rsp_data  = mem[optr];
   assign rsp_sop   = unl && (optr == '0);
   assign rsp_eop   = unl && (optr == total - 1'b1);
   assign rsp_err   = err_q;
endmodule

// File: rtl/cardlink_uart.sv
module cardlink_uart
   import cl_pkg::*;
#(
   parameter int unsigned CLKS_PER_BIT = 1042,
   parameter int unsigned MAX_LEN      = 32,
   parameter int unsigned GAP_CHARS    = 10,
   parameter logic [7:0]  DEF_NAD      = 8'h12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_data,
   input  logic       cmd_sop,
   input  logic       cmd_eop,
   output logic       cmd_ready,
   output logic       rsp_valid,
   output logic [7:0] rsp_data,
   output logic       rsp_sop,
   output logic       rsp_eop,
   output logic       rsp_err,
   output logic       txd,
   input  logic       rxd
);
   generate
      if (CLKS_PER_BIT < 4) begin : g_chk_cpb
         $error("CLKS_PER_BIT must be at least 4");
      end
      if (MAX_LEN < 1 || MAX_LEN > 255) begin : g_chk_len
         $error("MAX_LEN must lie in 1..255");
      end
      if (CHAR_BITS * CLKS_PER_BIT <= MAX_LEN + 4) begin : g_chk_unload
         $error("a response burst must finish within one character time");
      end
   endgenerate

   logic       chr_busy;
   logic       chr_start;
   logic [7:0] chr_data;
   logic [7:0] exp_nad;
   logic [7:0] rx_byte;
   logic       rx_bvalid;
   logic       rx_berr;

   cl_cmd_framer #(.DEF_NAD(DEF_NAD)) u_framer (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_sop(cmd_sop),
      .cmd_eop(cmd_eop), .cmd_ready(cmd_ready),
      .chr_busy(chr_busy), .chr_start(chr_start), .chr_data(chr_data),
      .exp_nad(exp_nad)
   );

   cl_char_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
      .clk(clk), .rst_n(rst_n), .start(chr_start), .data(chr_data),
      .busy(chr_busy), .txd(txd)
   );

   cl_char_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
      .clk(clk), .rst_n(rst_n), .rxd(rxd),
      .rx_byte(rx_byte), .rx_bvalid(rx_bvalid), .rx_berr(rx_berr)
   );

   cl_rsp_checker #(
      .CLKS_PER_BIT(CLKS_PER_BIT), .MAX_LEN(MAX_LEN), .GAP_CHARS(GAP_CHARS)
   ) u_chk (
      .clk(clk), .rst_n(rst_n),
      .rx_byte(rx_byte), .rx_bvalid(rx_bvalid), .rx_berr(rx_berr),
      .exp_nad(exp_nad),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_sop(rsp_sop),
      .rsp_eop(rsp_eop), .rsp_err(rsp_err)
   );
endmodule

// File: rtl/cardlink_sva.sv
module cardlink_sva
   import cl_pkg::*;
#(
   parameter logic [7:0] DEF_NAD = 8'h12
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [7:0] cmd_data,
   input logic       cmd_sop,
   input logic       cmd_eop,
   input logic       cmd_ready,
   input logic       rsp_valid,
   input logic [7:0] rsp_data,
   input logic       rsp_sop,
   input logic       rsp_eop,
   input logic       rsp_err,
   input logic       txd,
   input logic       rxd
);
   logic [7:0] exp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) exp_q <= nib_swap(DEF_NAD);
      else if (cmd_valid && cmd_ready && cmd_sop) exp_q <= nib_swap(cmd_data);
   end

   AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> txd); // R1
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready); // R2
   AST_RSP_NAD: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_sop) |-> (rsp_data == exp_q)); // R3
   AST_RSP_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_eop) |=> (rsp_valid && !rsp_sop)); // R4
   AST_RSP_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> rsp_sop); // R4
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |=> !rsp_err); // R5
   AST_ERR_APART: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> !rsp_valid); // R6
   AST_MIN_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_sop) |-> !rsp_eop); // R9
endmodule

bind cardlink_uart cardlink_sva #(.DEF_NAD(DEF_NAD)) i_sva (.*);

// File: tb/test_cardlink_uart.sv
module test_cardlink_uart;
   localparam int CLK_PERIOD = 10;
   localparam int CPB        = 8;
   localparam int MAXL       = 8;
   localparam int GAPC       = 10;
   localparam int CHAR_CLKS  = 12 * CPB;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_data = '0;
   logic       cmd_sop = 1'b0;
   logic       cmd_eop = 1'b0;
   logic       cmd_ready;
   logic       rsp_valid;
   logic [7:0] rsp_data;
   logic       rsp_sop;
   logic       rsp_eop;
   logic       rsp_err;
   logic       txd;
   logic       rxd = 1'b1;

   int checks = 0;
   int errors = 0;
   int err_seen = 0;
   logic [7:0] tx_exp [$];
   logic [9:0] rsp_exp [$];
   logic [7:0] pk [$];
   logic [7:0] pk2 [$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   cardlink_uart #(
      .CLKS_PER_BIT(CPB), .MAX_LEN(MAXL), .GAP_CHARS(GAPC), .DEF_NAD(8'h12)
   ) i_cardlink_uart (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_sop(cmd_sop),
      .cmd_eop(cmd_eop), .cmd_ready(cmd_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_sop(rsp_sop),
      .rsp_eop(rsp_eop), .rsp_err(rsp_err), .txd(txd), .rxd(rxd)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // host driver: pushes the bytes and their XOR onto the transmit scoreboard
   task automatic send_cmd(input logic [7:0] p [$]);
      logic [7:0] x = '0;
      @(negedge clk);
      foreach (p[i]) begin
         tx_exp.push_back(p[i]);
         x ^= p[i];
         cmd_valid = 1'b1;
         cmd_data  = p[i];
         cmd_sop   = (i == 0);
         cmd_eop   = (i == p.size() - 1);
         while (!cmd_ready) @(negedge clk);
         @(negedge clk);
         cmd_valid = 1'b0;
      end
      tx_exp.push_back(x);
   endtask

   task automatic ser_byte(input logic [7:0] b, input bit flip_par, input int gap);
      rxd = 1'b0;
      repeat (CPB) @(negedge clk);
      for (int k = 0; k < 8; k++) begin
         rxd = b[k];
         repeat (CPB) @(negedge clk);
      end
      rxd = (^b) ^ flip_par;
      repeat (CPB) @(negedge clk);
      rxd = 1'b1;
      repeat (2 * CPB + gap) @(negedge clk);
   endtask

   // serial responder: bcc_flip corrupts the check byte, par_idx picks a byte with bad parity
   task automatic send_rsp(input logic [7:0] p [$], input logic [7:0] bcc_flip,
                           input int par_idx, input int gap);
      logic [7:0] x = '0;
      @(negedge clk);
      foreach (p[i]) begin
         x ^= p[i];
         ser_byte(p[i], (i == par_idx), gap);
      end
      ser_byte(x ^ bcc_flip, 1'b0, gap);
   endtask

   task automatic expect_rsp(input logic [7:0] p [$]);
      foreach (p[i]) rsp_exp.push_back({(i == 0), (i == p.size() - 1), p[i]});
   endtask

   task automatic err_delta(input int base, input int n, input string tag);
      repeat (20) @(negedge clk);
      check(err_seen - base == n, tag, "error pulses", err_seen - base, n);
      check(rsp_exp.size() == 0, tag, "undelivered bytes", rsp_exp.size(), 0);
   endtask

   task automatic wait_tx();
      while (tx_exp.size() != 0) @(negedge clk);
   endtask

   // response monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_err) err_seen++;
         if (rsp_valid) begin
            if (rsp_exp.size() == 0) begin
               check(1'b0, "R4", "unexpected response byte", rsp_data, 0);
            end else begin
               logic [9:0] e;
               e = rsp_exp.pop_front();
               check({rsp_sop, rsp_eop, rsp_data} == e, "R4",
                     "response byte {sop,eop,data}", {rsp_sop, rsp_eop, rsp_data}, e);
            end
         end
      end
   end

   // transmit line monitor
   initial begin
      forever begin
         logic [7:0] b;
         logic [7:0] e;
         logic       par, st1, st2, sb;
         @(negedge clk);
         if (rst_n && txd == 1'b0) begin
            repeat (CPB / 2) @(negedge clk);
            sb = txd;
            for (int k = 0; k < 8; k++) begin
               repeat (CPB) @(negedge clk);
               b[k] = txd;
            end
            repeat (CPB) @(negedge clk);
            par = txd;
            repeat (CPB) @(negedge clk);
            st1 = txd;
            repeat (CPB) @(negedge clk);
            st2 = txd;
            check(sb == 1'b0 && st1 && st2, "R1", "start/stop bits", {sb, st1, st2}, 3'b011);
            check(par == ^b, "R1", "even parity bit", par, ^b);
            if (tx_exp.size() == 0) begin
               check(1'b0, "R2", "unexpected tx byte", b, 0);
            end else begin
               e = tx_exp.pop_front();
               check(b == e, "R2", "tx byte", b, e);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "R12", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      int base;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(txd == 1'b1, "R11", "txd after reset", txd, 1);
      check(cmd_ready == 1'b1, "R11", "cmd_ready after reset", cmd_ready, 1);
      check(rsp_valid == 1'b0, "R11", "rsp_valid after reset", rsp_valid, 0);
      check(rsp_err == 1'b0, "R11", "rsp_err after reset", rsp_err, 0);

      // R3 default expected address 0x21 before any command
      base = err_seen;
      pk = '{8'h21, 8'h00, 8'h02, 8'h62, 8'h00};
      expect_rsp(pk);
      send_rsp(pk, 8'h00, -1, 0);
      err_delta(base, 0, "R3");

      // R1 R2 main-slot reset command, check byte 0x05
      pk = '{8'h12, 8'h00, 8'h05, 8'h00, 8'h12, 8'h00, 8'h00, 8'h00};
      send_cmd(pk);
      wait_tx();
      check(tx_exp.size() == 0, "R2", "tx scoreboard drained", tx_exp.size(), 0);

      // R3 secondary slot command changes expected address to 0x31
      pk = '{8'h13, 8'h00, 8'h01, 8'hA4};
      send_cmd(pk);
      wait_tx();
      base = err_seen;
      pk = '{8'h31, 8'h00, 8'h02, 8'h62, 8'h00};
      expect_rsp(pk);
      send_rsp(pk, 8'h00, -1, 0);
      err_delta(base, 0, "R3");

      // R7 stale address 0x21 now rejected
      base = err_seen;
      pk = '{8'h21, 8'h00, 8'h02, 8'h62, 8'h00};
      send_rsp(pk, 8'h00, -1, 0);
      err_delta(base, 1, "R7");

      pk = '{8'h12, 8'h00, 8'h00};
      send_cmd(pk);
      wait_tx();

      // R5 corrupted check byte
      base = err_seen;
      pk = '{8'h21, 8'h00, 8'h02, 8'h62, 8'h00};
      send_rsp(pk, 8'h40, -1, 0);
      err_delta(base, 1, "R5");

      // R6 parity error in the length byte
      base = err_seen;
      send_rsp(pk, 8'h00, 2, 0);
      err_delta(base, 1, "R6");

      // R8 length above MAX_LEN, otherwise consistent
      base = err_seen;
      pk = '{8'h21, 8'h00, 8'h09, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05,
             8'h06, 8'h07, 8'h08, 8'h09};
      send_rsp(pk, 8'h00, -1, 0);
      err_delta(base, 1, "R8");

      // R9 zero length
      base = err_seen;
      pk = '{8'h21, 8'h00, 8'h00};
      expect_rsp(pk);
      send_rsp(pk, 8'h00, -1, 0);
      err_delta(base, 0, "R9");

      // R4 full MAX_LEN data
      base = err_seen;
      pk = '{8'h21, 8'h40, 8'h08, 8'h3B, 8'h7A, 8'h18, 8'hFF, 8'h00,
             8'h90, 8'h55, 8'hAA};
      expect_rsp(pk);
      send_rsp(pk, 8'h00, -1, 0);
      err_delta(base, 0, "R4");

      // R10 gap abort, then a clean packet
      base = err_seen;
      @(negedge clk);
      ser_byte(8'h21, 1'b0, 0);
      ser_byte(8'h00, 1'b0, 0);
      ser_byte(8'h02, 1'b0, 0);
      repeat ((GAPC + 3) * CHAR_CLKS) @(negedge clk);
      check(err_seen - base == 1, "R10", "gap abort pulse", err_seen - base, 1);
      pk = '{8'h21, 8'h00, 8'h01, 8'h5A};
      expect_rsp(pk);
      send_rsp(pk, 8'h00, -1, 0);
      err_delta(base, 1, "R10");

      // R10 gaps just below the limit
      base = err_seen;
      pk = '{8'h21, 8'h00, 8'h01, 8'hC3};
      expect_rsp(pk);
      send_rsp(pk, 8'h00, -1, (GAPC - 1) * CHAR_CLKS);
      err_delta(base, 0, "R10");

      // R12 command and response concurrently
      base = err_seen;
      pk  = '{8'h12, 8'h00, 8'h03, 8'h11, 8'h22, 8'h33};
      pk2 = '{8'h21, 8'h00, 8'h02, 8'h90, 8'h00};
      expect_rsp(pk2);
      fork
         send_cmd(pk);
         send_rsp(pk2, 8'h00, -1, 0);
      join
      wait_tx();
      err_delta(base, 0, "R12");
      check(tx_exp.size() == 0, "R12", "tx scoreboard drained", tx_exp.size(), 0);

      repeat (50) @(negedge clk);
      finish_run();
   end
endmodule